// File: doc/BRIEF.md
# Systolic GF(2^n) Constant Multiplier Array

This block multiplies field elements over GF(2^n) by a constant that is fixed when the design is built. The constant is an n-by-n bit matrix over GF(2). Each new state bit is the parity of the present-state bits that the matrix selects. The state is not held in one register whose outputs fan out across the XOR columns. Instead, every state bit circulates through its own row shift line. The parity for each new bit is formed by a column chain that is registered once at every row crossing. As a result, every path from a state bit back to itself holds exactly n registers. Between any two registers there is at most one XOR (or one XOR and the load multiplexer), and a row tap feeds a single XOR site.

Because every loop is n registers deep, the array carries n independent computations interleaved in time, one per cycle slot. A word that is loaded into a slot comes out n cycles later. After that, every n cycles the same slot shows that word multiplied by the constant once more. This gives the throughput of n separate constant multipliers, each advancing one step every n cycles. Loading is done by asserting the load strobe with an initial word. Consecutive load cycles fill consecutive slots. The state bits are skewed by column inside the array. Input and output delay lines remove that skew, so the port sees whole state vectors.

Top module: `gfsys_cmul_array`

## Requirements
- R1: While reset is asserted, and afterwards until the first loaded word has had time to come out, `state_out` is all zero.
- R2: A word presented on `init_word` with `load` high appears unchanged on `state_out` exactly N clock cycles later (N = 8 by default).
- R3: In a cycle slot that is not reloaded, `state_out` N cycles later equals s', where s'[c] is the XOR over all rows r of (MATRIX[r*N + c] AND s[r]), and bit 0 is the least significant. The default matrix is multiplication by x modulo x^8 + x^4 + x^3 + x^2 + 1 (0x11D): s' = (s << 1) XOR (s[7] ? 0x1D : 0), truncated to 8 bits.
- R4: Words loaded in N consecutive cycles occupy N slots that evolve independently. Output cycle m belongs to the same slot as output cycle m + N.
- R5: A single load while the array is running replaces only the slot of that cycle. Every other slot continues its own sequence undisturbed.
- R6: When `load` is held high for more than N cycles, each cycle overwrites its slot. After the strobe drops, the slots continue from the last N words that were loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low; clears all state |
| load | input | 1 | Loads `init_word` into the slot of this cycle |
| init_word | input | N | Initial state word for the slot being loaded |
| state_out | output | N | Deskewed state vector of the slot leaving the array this cycle |

## Verification
The bench goes after the exact load-to-output latency. If a design gets that latency wrong by one register, every word comes out in the wrong slot and the whole stream is shifted. Long free-running stretches check that the tap chosen for each column is right. An off-by-one tap mixes bits from neighbouring slots, and the parity then drifts away from repeated multiplication by x. A single reload in the middle of a run, and a load burst longer than N, check that the load multiplexer and its skew line act on exactly one slot. If they leak, neighbouring slots get corrupted or an earlier word survives.

// File: rtl/gfsys_pkg.sv
package gfsys_pkg;
   localparam int unsigned MAX_N = 32;

   typedef struct packed {
      logic ld;
      logic val;
   } inj_t;
endpackage

// File: rtl/gfsys_delay.sv
// Fixed-depth register delay line (DEPTH >= 1), async reset to zero.
module gfsys_delay #(
   parameter int unsigned WIDTH = 1,
   parameter int unsigned DEPTH = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < int'(DEPTH); i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[DEPTH-1];
endmodule

// File: rtl/gfsys_row.sv
// Row feedback line: taps[j] is the row source delayed by j cycles.
module gfsys_row #(
   parameter int unsigned N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         src,
   output logic [N-1:0] taps
);
   logic [N-2:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= '0;
      end else begin
         stg[0] <= src;
         for (int j = 1; j < int'(N) - 1; j++) stg[j] <= stg[j-1];
      end
   end

   assign taps = {stg, src};
endmodule

// File: rtl/gfsys_column.sv
// Pipelined parity column: one register per row crossing, XOR site where
// the constant matrix has a one, load multiplexer on the final stage.
module gfsys_column #(
   parameter int unsigned N      = 8,
   parameter int unsigned COL    = 0,
   parameter logic [N*N-1:0] MATRIX = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] taps,
   input  logic         inj_ld,
   input  logic         inj_val,
   output logic         state_bit
);
   logic [N-1:0] acc;

   for (genvar r = 0; r < int'(N); r++) begin : g_cross
      localparam bit SITE = MATRIX[r*N + COL];
      logic prev;
      logic mixed;

      if (r == 0) begin : g_head
         assign prev = 1'b0;
      end else begin : g_link
         assign prev = acc[r-1];
      end

      assign mixed = prev ^ (taps[r] & SITE);

      if (r == int'(N) - 1) begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      acc[r] <= 1'b0;
            else if (inj_ld) acc[r] <= inj_val;
            else             acc[r] <= mixed;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) acc[r] <= 1'b0;
            else        acc[r] <= mixed;
         end
      end
   end

   assign state_bit = acc[N-1];
endmodule

// File: rtl/gfsys_cmul_array.sv
// Two-dimensional systolic constant multiplier over GF(2^N).
module gfsys_cmul_array #(
   parameter int unsigned    N      = 8,
   parameter logic [N*N-1:0] MATRIX = 64'h1D80_4020_1008_0402
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [N-1:0] init_word,
   output logic [N-1:0] state_out
);
   import gfsys_pkg::*;

   localparam int unsigned INJ_W = $bits(inj_t);

   if (N < 2 || N > MAX_N) begin : g_bad_width
      $error("gfsys_cmul_array: N out of supported range");
   end

   logic [N-1:0] st;
   logic [N-1:0] row_tap [N];
   logic [N-1:0] col_tap [N];
   inj_t         inj_raw [N];
   inj_t         inj_sk  [N];

   // Row feedback lines, one per state bit.
   for (genvar r = 0; r < int'(N); r++) begin : g_row
      gfsys_row #(.N(N)) u_row (
         .clk   (clk),
         .rst_n (rst_n),
         .src   (st[r]),
         .taps  (row_tap[r])
      );
   end

   // Column c reads each row at delay c, which closes every loop at N.
   for (genvar c = 0; c < int'(N); c++) begin : g_col
      for (genvar r = 0; r < int'(N); r++) begin : g_wire
         assign col_tap[c][r] = row_tap[r][c];
      end

      assign inj_raw[c] = '{ld: load, val: init_word[c]};

      // Input skew: column c is loaded c cycles after column 0.
      if (c == 0) begin : g_inj_direct
         assign inj_sk[c] = inj_raw[c];
      end else begin : g_inj_skew
         gfsys_delay #(.WIDTH(INJ_W), .DEPTH(c)) u_inj_dly (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (inj_raw[c]),
            .q     (inj_sk[c])
         );
      end

      gfsys_column #(.N(N), .COL(c), .MATRIX(MATRIX)) u_col (
         .clk       (clk),
         .rst_n     (rst_n),
         .taps      (col_tap[c]),
         .inj_ld    (inj_sk[c].ld),
         .inj_val   (inj_sk[c].val),
         .state_bit (st[c])
      );

      // Output deskew: column c waits N-1-c cycles to line up.
      if (c == int'(N) - 1) begin : g_out_direct
         assign state_out[c] = st[c];
      end else begin : g_out_skew
         gfsys_delay #(.WIDTH(1), .DEPTH(N - 1 - c)) u_out_dly (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (st[c]),
            .q     (state_out[c])
         );
      end
   end
endmodule

// File: rtl/gfsys_cmul_array_chk.sv
// Port-level checker, attached to the array with bind.
module gfsys_cmul_array_chk #(
   parameter int unsigned    N      = 8,
   parameter logic [N*N-1:0] MATRIX = '0
) (
   input logic         clk,
   input logic         rst_n,
   input logic         load,
   input logic [N-1:0] init_word,
   input logic [N-1:0] state_out
);
   logic [N-1:0] hist_ld;
   logic [N-1:0] hist_w   [N];
   logic [N-1:0] hist_out [N];
   int unsigned  cnt;

   function automatic logic [N-1:0] apply_m(input logic [N-1:0] s);
      logic [N-1:0] v;
      v = '0;
      for (int c = 0; c < int'(N); c++)
         for (int r = 0; r < int'(N); r++)
            if (MATRIX[r*N + c]) v[c] = v[c] ^ s[r];
      return v;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_ld <= '0;
         cnt     <= 0;
         for (int i = 0; i < int'(N); i++) begin
            hist_w[i]   <= '0;
            hist_out[i] <= '0;
         end
      end else begin
         hist_ld     <= {hist_ld[N-2:0], load};
         hist_w[0]   <= init_word;
         hist_out[0] <= state_out;
         for (int i = 1; i < int'(N); i++) begin
            hist_w[i]   <= hist_w[i-1];
            hist_out[i] <= hist_out[i-1];
         end
         if (cnt < N) cnt <= cnt + 1;
      end
   end

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |-> state_out == '0);

   assert_quiet_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < N |-> state_out == '0);

   assert_load_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hist_ld[N-1] |-> state_out == hist_w[N-1]);

   assert_slot_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !hist_ld[N-1] |-> state_out == apply_m(hist_out[N-1]));
endmodule

bind gfsys_cmul_array gfsys_cmul_array_chk #(.N(N), .MATRIX(MATRIX)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .load      (load),
   .init_word (init_word),
   .state_out (state_out)
);

// File: tb/gfsys_cmul_array_bench.sv
module gfsys_cmul_array_bench;
   localparam int  N          = 8;
   localparam time CLK_PERIOD = 10ns;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         load = 1'b0;
   logic [N-1:0] init_word = '0;
   logic [N-1:0] state_out;

   int           n_checks = 0;
   int           n_fails  = 0;
   int           cyc      = 0;
   logic [N-1:0] model [N];

   always #(CLK_PERIOD/2) clk = ~clk;

   gfsys_cmul_array u_gfsys_cmul_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .init_word (init_word),
      .state_out (state_out)
   );

   // Multiplication by x modulo x^8+x^4+x^3+x^2+1.
   function automatic logic [7:0] mul_x(input logic [7:0] s);
      return {s[6:0], 1'b0} ^ (s[7] ? 8'h1D : 8'h00);
   endfunction

   task automatic check(input string tag, input logic [N-1:0] act,
                        input logic [N-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: state_out=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // One cycle: check the slot leaving now, advance model, drive inputs.
   task automatic step(input logic ld, input logic [N-1:0] w, input string tag);
      int slot;
      @(negedge clk);
      slot = cyc % N;
      check(tag, state_out, model[slot]);
      model[slot] = mul_x(model[slot]);
      if (ld) model[slot] = w;
      load      = ld;
      init_word = w;
      cyc++;
   endtask

   task automatic t_reset_R1();
      rst_n = 1'b0;
      load  = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", state_out, '0);
      rst_n = 1'b1;
      cyc = 0;
      for (int i = 0; i < N; i++) model[i] = '0;
      for (int i = 0; i < 2*N; i++) step(1'b0, '0, "R1");
   endtask

   task automatic t_fill_R4();
      logic [N-1:0] words [N];
      words = '{8'h01, 8'h80, 8'h53, 8'hFF, 8'h00, 8'hCA, 8'h1D, 8'h7E};
      for (int i = 0; i < N; i++) step(1'b1, words[i], "R4");
      for (int i = 0; i < N; i++) step(1'b0, '0, "R2");
      for (int i = 0; i < 6*N; i++) step(1'b0, '0, "R3");
   endtask

   task automatic t_reload_R5();
      step(1'b0, '0, "R5");
      step(1'b0, '0, "R5");
      step(1'b1, 8'hA5, "R5");
      for (int i = 0; i < 4*N; i++) step(1'b0, '0, "R5");
      step(1'b1, 8'h00, "R5");
      for (int i = 0; i < 3*N; i++) step(1'b0, '0, "R5");
   endtask

   task automatic t_burst_R6();
      for (int i = 0; i < 3*N; i++) step(1'b1, 8'(8'h11 * i + 3), "R6");
      for (int i = 0; i < 4*N; i++) step(1'b0, '0, "R6");
   endtask

   task automatic t_long_run_R3();
      for (int i = 0; i < 300*N; i++) step(1'b0, '0, "R3");
   endtask

   initial begin
      t_reset_R1();
      t_fill_R4();
      t_reload_R5();
      t_burst_R6();
      t_long_run_R3();
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end
endmodule